// File: doc/BRIEF.md
# RC PUF Challenge Sequencer

This block turns a 32-bit challenge into a timed serial waveform on a single output pin that drives an external resistor-capacitor network. Each challenge bit stays on the pin for one hold period, least significant bit first. Once the last bit has been applied, the block asks an external converter for one 12-bit sample. It keeps one mid-significance bit of that sample as the raw response. The whole pass is repeated a configurable number of times, and a majority vote over the raw bits gives the final response bit.

The hold period is counted in microseconds. A prescaler derives each microsecond from the system clock, so the total response time depends only on the hold period and the repeat count. In fixed mode every device uses the same hold period. In the two variable modes a per-device calibration value is added to the base, so the hold period differs between devices but stays constant on any one device. All settings are captured when a run starts.

Top module: `rcpuf_seq`

## Requirements
- R1: The challenge is driven LSB first. Bit k is on `pin` for exactly D*CLK_PER_US cycles, starting D*CLK_PER_US*k cycles after the cycle that follows the accepted start, where D is the hold period in microseconds. `pin` is 0 whenever `busy` is 0.
- R2: Exactly D*CLK_PER_US*32 cycles after the run starts, `adc_req` is high for one cycle. `pin` then keeps challenge bit 31 until `adc_done` is seen. `adc_done` is acted on only in the cycles after the request and has no effect at any other time.
- R3: Delay mode value 0 or 3 selects fixed mode, where D = `base_dly`. In every mode a computed D of 0 is replaced by 1.
- R4: Delay mode value 1 gives D = `base_dly` + `cal_val`[3:0], ignoring `cal_val`[4]. Delay mode value 2 gives D = `base_dly` + `cal_val`[4:0].
- R5: `bit_sel` picks the raw response bit from `adc_data`: value 1 picks bit 4, value 2 picks bit 6, and values 0 and 3 pick bit 5.
- R6: The pass repeats `rep_cnt` times. `resp_bit` is 1 only if strictly more than half the raw bits are 1, so a tie gives 0.
- R7: A `rep_cnt` of 0 performs exactly one pass.
- R8: `start` and all settings are sampled only when `busy` is 0. A start pulse or a settings change during a run has no effect on that run.
- R9: `resp_valid` is high for one cycle, in the cycle after the final `adc_done`. In that cycle `busy` is already 0. `resp_bit` holds its value until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (sampled when idle) |
| challenge | input | 32 | Challenge word |
| dly_mode | input | 2 | 0/3 fixed, 1 base+4-bit cal, 2 base+5-bit cal |
| base_dly | input | 6 | Base hold period in microseconds |
| cal_val | input | 5 | Per-device calibration value |
| rep_cnt | input | 7 | Number of passes (0 treated as 1) |
| bit_sel | input | 2 | Raw bit position select |
| adc_req | output | 1 | One-cycle conversion request |
| adc_done | input | 1 | Conversion finished strobe |
| adc_data | input | 12 | Conversion result, valid with adc_done |
| pin | output | 1 | Drive to the RC network |
| busy | output | 1 | Run in progress |
| resp_valid | output | 1 | One-cycle result strobe |
| resp_bit | output | 1 | Voted response bit |

## Verification
A wrong bit index or a wrong hold counter shows up on `pin` within one hold period, and the bench compares the pin against the challenge in every cycle. A prescaler or delay-sum error moves the conversion request away from its expected cycle, so it is caught when the first pass ends. An error in the vote counter or the pass counter becomes visible only at `resp_valid` after the last pass. For that reason the bench uses repeat counts from 1 to 5, including ties, and data words in which the candidate bit positions differ.

// File: rtl/rcpuf_seq.sv
module rcpuf_seq #(
  parameter int CLK_PER_US = 2,
  parameter int CHAL_W     = 32,
  parameter int ADC_W      = 12,
  parameter int BASE_W     = 6,
  parameter int CAL_W      = 5,
  parameter int REP_W      = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CHAL_W-1:0] challenge,
  input  logic [1:0]        dly_mode,
  input  logic [BASE_W-1:0] base_dly,
  input  logic [CAL_W-1:0]  cal_val,
  input  logic [REP_W-1:0]  rep_cnt,
  input  logic [1:0]        bit_sel,
  output logic              adc_req,
  input  logic              adc_done,
  input  logic [ADC_W-1:0]  adc_data,
  output logic              pin,
  output logic              busy,
  output logic              resp_valid,
  output logic              resp_bit
);
  localparam int DLY_W = BASE_W + 1;
  localparam int IDX_W = $clog2(CHAL_W);
  localparam int PRE_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam int POS_MID = 5;
  localparam int POS_LO  = 4;
  localparam int POS_HI  = 6;

  typedef enum logic [1:0] {S_IDLE, S_DRIVE, S_REQ, S_WAIT} state_t;

  state_t            state;
  logic [CHAL_W-1:0] chal_q;
  logic [DLY_W-1:0]  dly_q, dly_calc, dly_sum;
  logic [REP_W-1:0]  reps_q, rep_q, rep_nx, ones_q, ones_nx;
  logic [1:0]        sel_q;
  logic [IDX_W-1:0]  idx;
  logic [PRE_W-1:0]  pre;
  logic [DLY_W-1:0]  us;
  logic              raw;
  logic              unused_bits;

  always_comb begin
    case (dly_mode)
      2'd1:    dly_sum = DLY_W'(base_dly) + DLY_W'(cal_val[3:0]);
      2'd2:    dly_sum = DLY_W'(base_dly) + DLY_W'(cal_val);
      default: dly_sum = DLY_W'(base_dly);
    endcase
    dly_calc = (dly_sum == '0) ? DLY_W'(1) : dly_sum;
  end

  always_comb begin
    case (sel_q)
      2'd1:    raw = adc_data[POS_LO];
      2'd2:    raw = adc_data[POS_HI];
      default: raw = adc_data[POS_MID];
    endcase
  end

  assign unused_bits = ^{adc_data[ADC_W-1:POS_HI+1], adc_data[POS_LO-1:0]};
  assign rep_nx  = rep_q + 1'b1;
  assign ones_nx = ones_q + REP_W'(raw);
  assign adc_req = (state == S_REQ);
  assign busy    = (state != S_IDLE);
  assign pin     = busy & chal_q[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      chal_q     <= '0;
      dly_q      <= DLY_W'(1);
      reps_q     <= REP_W'(1);
      rep_q      <= '0;
      ones_q     <= '0;
      sel_q      <= '0;
      idx        <= '0;
      pre        <= '0;
      us         <= '0;
      resp_valid <= 1'b0;
      resp_bit   <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          chal_q <= challenge;
          dly_q  <= dly_calc;
          reps_q <= (rep_cnt == '0) ? REP_W'(1) : rep_cnt;
          sel_q  <= bit_sel;
          rep_q  <= '0;
          ones_q <= '0;
          idx    <= '0;
          pre    <= '0;
          us     <= '0;
          state  <= S_DRIVE;
        end
        S_DRIVE: begin
          if (pre == PRE_W'(CLK_PER_US - 1)) begin
            pre <= '0;
            if (us == dly_q - 1'b1) begin
              us <= '0;
              if (idx == IDX_W'(CHAL_W - 1)) state <= S_REQ;
              else idx <= idx + 1'b1;
            end else begin
              us <= us + 1'b1;
            end
          end else begin
            pre <= pre + 1'b1;
          end
        end
        S_REQ: state <= S_WAIT;
        S_WAIT: if (adc_done) begin
          if (rep_nx == reps_q) begin
            resp_valid <= 1'b1;
            resp_bit   <= ({ones_nx, 1'b0} > {1'b0, reps_q});
            state      <= S_IDLE;
          end else begin
            rep_q  <= rep_nx;
            ones_q <= ones_nx;
            idx    <= '0;
            state  <= S_DRIVE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rcpuf_seq_chk.sv
module rcpuf_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic pin,
  input logic adc_req,
  input logic resp_valid
);
  assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !pin);
  assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n) adc_req |=> !adc_req);
  assert_req_busy_R2: assert property (@(posedge clk) disable iff (!rst_n) adc_req |-> busy);
  assert_pin_hold_R2: assert property (@(posedge clk) disable iff (!rst_n) adc_req |=> $stable(pin));
  assert_start_idle_R8: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy);
  assert_busy_cause_R8: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start));
  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n) resp_valid |=> !resp_valid);
  assert_valid_idle_R9: assert property (@(posedge clk) disable iff (!rst_n) resp_valid |-> !busy);
endmodule

bind rcpuf_seq rcpuf_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .pin(pin), .adc_req(adc_req), .resp_valid(resp_valid)
);

// File: tb/tb_rcpuf_seq.sv
`timescale 1ns/1ps
module tb_rcpuf_seq;
  localparam int P = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] challenge = '0;
  logic [1:0]  dly_mode = '0;
  logic [5:0]  base_dly = '0;
  logic [4:0]  cal_val = '0;
  logic [6:0]  rep_cnt = '0;
  logic [1:0]  bit_sel = '0;
  logic        adc_done = 1'b0;
  logic [11:0] adc_data = '0;
  logic        adc_req, pin, busy, resp_valid, resp_bit;

  int errors = 0;
  int checks = 0;
  logic [11:0] dw [8];

  always #2 clk = ~clk;

  rcpuf_seq #(.CLK_PER_US(P)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .challenge(challenge),
    .dly_mode(dly_mode), .base_dly(base_dly), .cal_val(cal_val),
    .rep_cnt(rep_cnt), .bit_sel(bit_sel), .adc_req(adc_req),
    .adc_done(adc_done), .adc_data(adc_data), .pin(pin), .busy(busy),
    .resp_valid(resp_valid), .resp_bit(resp_bit)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run(input logic [31:0] ch, input logic [1:0] md, input int base,
                     input int cal, input int reps, input int sel, input int lat,
                     input bit poke, input string req);
    int d, n, pos, ones;
    logic expb;
    case (md)
      2'd1: d = base + (cal & 15);
      2'd2: d = base + cal;
      default: d = base;
    endcase
    if (d == 0) d = 1;
    n = (reps == 0) ? 1 : reps;
    pos = (sel == 1) ? 4 : (sel == 2) ? 6 : 5;
    ones = 0;
    for (int r = 0; r < n; r++) ones += dw[r][pos];
    expb = (2 * ones > n);
    @(negedge clk);
    challenge = ch; dly_mode = md; base_dly = 6'(base); cal_val = 5'(cal);
    rep_cnt = 7'(reps); bit_sel = 2'(sel); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    challenge = ~ch; dly_mode = ~md; base_dly = 6'd50; rep_cnt = 7'd9; bit_sel = ~bit_sel;
    for (int r = 0; r < n; r++) begin
      for (int t = 0; t < 32 * d * P; t++) begin
        chk(pin == ch[t / (d * P)], req, pin, ch[t / (d * P)]);
        chk(!adc_req && busy, "R2", adc_req, 0);
        if (poke && r == 0 && t == 3) begin start = 1'b1; adc_done = 1'b1; adc_data = '1; end
        if (poke && r == 0 && t == 4) begin start = 1'b0; adc_done = 1'b0; adc_data = '0; end
        @(negedge clk);
      end
      chk(adc_req == 1'b1, "R2", adc_req, 1);
      chk(pin == ch[31], "R2", pin, ch[31]);
      for (int k = 0; k < lat; k++) begin
        @(negedge clk);
        chk(!adc_req && pin == ch[31] && busy, "R2", pin, ch[31]);
      end
      adc_done = 1'b1; adc_data = dw[r];
      @(negedge clk);
      adc_done = 1'b0; adc_data = ~dw[r];
      if (r == n - 1) begin
        chk(resp_valid == 1'b1, "R9", resp_valid, 1);
        chk(resp_bit == expb, req, resp_bit, expb);
        chk(!busy && !pin, "R9", busy, 0);
        @(negedge clk);
        chk(resp_valid == 1'b0, "R9", resp_valid, 0);
        chk(resp_bit == expb, "R9", resp_bit, expb);
      end else begin
        chk(resp_valid == 1'b0 && busy, "R6", resp_valid, 0);
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !pin && !adc_req && !resp_valid && !resp_bit, "R1", busy, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !pin, "R1", busy, 0);

    dw[0] = 12'h020; dw[1] = 12'h000; dw[2] = 12'h020;
    run(32'h5A5A5A5A, 2'd0, 1, 0, 3, 0, 1, 0, "R1");
    dw[0] = 12'h020; dw[1] = 12'h000;
    run(32'hCCCCCCCC, 2'd0, 2, 7, 2, 0, 3, 0, "R6");
    dw[0] = 12'h020;
    run(32'hA5A5A5A5, 2'd3, 0, 0, 0, 0, 2, 0, "R7");
    dw[0] = 12'h000;
    run(32'h80000001, 2'd0, 0, 31, 1, 0, 1, 0, "R3");
    dw[0] = 12'h020;
    run(32'h5ACCCCCC, 2'd1, 1, 19, 1, 0, 1, 0, "R4");
    run(32'h5A5CCCCC, 2'd2, 1, 19, 1, 3, 4, 0, "R4");
    for (int s = 0; s < 4; s++) begin
      dw[0] = 12'hFAF;
      run(32'h0F0F3C3C, 2'd0, 1, 0, 1, s, 1, 0, "R5");
      dw[0] = 12'h050;
      run(32'hF0F0C3C3, 2'd0, 1, 0, 1, s, 2, 0, "R5");
    end
    dw[0] = 12'h020; dw[1] = 12'h000; dw[2] = 12'h020; dw[3] = 12'h020;
    run(32'h13579BDF, 2'd0, 1, 0, 4, 0, 1, 0, "R6");
    dw[0] = 12'h000; dw[1] = 12'h020; dw[2] = 12'h000; dw[3] = 12'h020; dw[4] = 12'h000;
    run(32'h2468ACE0, 2'd0, 1, 0, 5, 0, 2, 0, "R6");
    dw[0] = 12'h000; dw[1] = 12'h000;
    run(32'h12345678, 2'd0, 1, 0, 2, 0, 2, 1, "R8");
    repeat (3) @(negedge clk);
    chk(!busy && !pin, "R8", busy, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule